// File: doc/BRIEF.md
# Linked-Descriptor Transfer Channel

This block is one channel of a scatter/gather engine. Software places buffer descriptors in a small descriptor memory that sits inside the block. Each descriptor is four 32-bit words at byte offsets 0, 4, 8 and 12 from a 16-byte-aligned address. Software then writes the address of the first descriptor to the head register. The engine reads the four words of that descriptor and checks that the descriptor belongs to the hardware. It then hands the buffer pointer and byte count to a downstream mover over a valid/ready request port, and waits for a done pulse that returns the length actually moved.

When the mover finishes, the engine rewrites the descriptor's mode word. Ownership is handed back to software, the length is updated, and the queue-end and teardown marks are set as needed. The engine publishes the descriptor's address in the completion register and raises a completion flag, which software clears by writing the same value back. The engine then follows the next pointer. A zero next pointer ends the queue: the engine returns to idle until software writes the head register again.

A teardown command aborts the channel at a clean descriptor boundary. The engine reports the abort with the marker 0xFFFFFFFC in the completion register.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset `busy`, `xfer_valid`, `cmpl_irq`, `head_ptr` and `cmpl_ptr` are all 0.
- R2: A head write of a non-zero address while idle starts the channel. The descriptor at that address is read as four words: next pointer (offset 0), buffer pointer (offset 4), length word (offset 8) and mode word (offset 12). The request then carries the buffer pointer on `xfer_addr` and the low LEN_W bits of the length word on `xfer_len`.
- R3: Once `xfer_valid` is high, it and the request fields stay unchanged until a cycle with `xfer_ready` high. Each descriptor raises exactly one request, and `xfer_valid` is low while the engine waits for `xfer_done`.
- R4: A descriptor whose mode bit 29 (owner) is 0 raises no request and is not written. The channel goes idle with `head_ptr` equal to 0.
- R5: On `xfer_done`, the mode word is rewritten as follows. Bit 29 becomes 0, bit 27 (teardown-complete) becomes 0, and bits 10:0 take the done length. All other bits are kept. `cmpl_ptr` takes the descriptor's address and `cmpl_irq` is set.
- R6: When mode bit 26 (pass-CRC) is set, the written length is the done length plus 4, modulo 2^11.
- R7: A non-zero next pointer makes the engine continue with that descriptor, and writes bit 28 (end-of-queue) as 0. A zero next pointer makes it write bit 28 as 1 and go idle with `head_ptr` equal to 0. A later head write restarts the channel.
- R8: A head write while the channel is busy, or a head write of 0, has no effect.
- R9: A write to `cmpl_we` whose value equals `cmpl_ptr` clears `cmpl_irq`. A write of any other value leaves it set.
- R10: A teardown write whose channel number equals CHAN_ID works as follows. While busy, the current descriptor finishes any request already raised. Its mode word is then written with bit 29 = 0 and bits 28 and 27 = 1, and its length is updated only if a transfer took place. No further descriptor is read. `cmpl_ptr` becomes 0xFFFFFFFC, `cmpl_irq` is set, and the channel goes idle with `head_ptr` equal to 0. While idle, the marker and the flag are set at once. A teardown naming another channel is ignored.
- R11: `xfer_dir_en` is 1 only when mode bit 20 is set and mode bits 18:16 equal 1 or 2. In that case `xfer_port` carries bits 18:16; otherwise both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_we | input | 1 | Software write strobe for the descriptor memory |
| mem_idx | input | IDX_W | Word index for software access (byte address / 4) |
| mem_wdata | input | 32 | Software write data |
| mem_rdata | output | 32 | Word at `mem_idx` (combinational) |
| head_we | input | 1 | Head register write strobe |
| head_wdata | input | 32 | First descriptor byte address |
| head_ptr | output | 32 | Descriptor being processed, 0 when idle |
| cmpl_we | input | 1 | Completion acknowledge strobe |
| cmpl_wdata | input | 32 | Acknowledge value |
| cmpl_ptr | output | 32 | Last completed descriptor or teardown marker |
| cmpl_irq | output | 1 | Completion not yet acknowledged |
| tdown_we | input | 1 | Teardown command strobe |
| tdown_chan | input | CH_W | Channel number of the teardown command |
| busy | output | 1 | Channel is walking descriptors |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Mover accepts the request |
| xfer_addr | output | 32 | Buffer pointer |
| xfer_len | output | LEN_W | Buffer byte count |
| xfer_dir_en | output | 1 | Directed output enabled |
| xfer_port | output | 3 | Target port when directed |
| xfer_done | input | 1 | One-cycle pulse: transfer finished |
| xfer_done_len | input | 11 | Bytes actually moved |

## Verification
Several properties are checked on every cycle by the assertions:
- the request holds with stable fields under back-pressure;
- the channel only wakes up because of a head write;
- an unowned descriptor never leads to a request;
- a teardown always lands in idle with a cleared head;
- the completion flag only rises on an engine report, and a matching acknowledge clears it;
- the directed port is never outside 1 and 2.

Other behaviour can only be shown by the bench's scenarios: the contents written back into each descriptor's mode word, the CRC length adjustment with wrap-around, the order in which chained buffers are requested, the ignored head and teardown writes, and the exact marker left by a teardown during fetch versus one during a transfer.

// File: rtl/dchan_pkg.sv
package dchan_pkg;
  localparam int BIT_SOP   = 31;
  localparam int BIT_EOP   = 30;
  localparam int BIT_OWN   = 29;
  localparam int BIT_EOQ   = 28;
  localparam int BIT_TDC   = 27;
  localparam int BIT_CRC   = 26;
  localparam int BIT_DIR   = 20;
  localparam int PORT_LSB  = 16;
  localparam int PKTLEN_W  = 11;
  localparam int CRC_BYTES = 4;
  localparam logic [31:0] TD_MARK = 32'hFFFF_FFFC;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_NEXT,
    ST_RD_BUF,
    ST_RD_LEN,
    ST_RD_MODE,
    ST_REQ,
    ST_WAIT,
    ST_WB
  } dchan_state_t;
endpackage

// File: rtl/dchan_mem.sv
module dchan_mem #(
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  input  logic [IDX_W-1:0] eng_ridx,
  output logic [31:0]      eng_rdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_widx,
  input  logic [31:0]      eng_wdata
);
  logic [31:0] store [WORDS];

  // engine write is placed last so it wins a same-address collision
  always_ff @(posedge clk) begin
    if (sw_we) store[sw_idx] <= sw_wdata;
    if (eng_we) store[eng_widx] <= eng_wdata;
  end

  assign sw_rdata  = store[sw_idx];
  assign eng_rdata = store[eng_ridx];
endmodule

// File: rtl/dchan_cmpl.sv
module dchan_cmpl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        eng_set,
  input  logic [31:0] eng_val,
  input  logic        sw_we,
  input  logic [31:0] sw_val,
  output logic [31:0] cmpl_ptr,
  output logic        cmpl_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpl_ptr <= '0;
      cmpl_irq <= 1'b0;
    end else if (eng_set) begin
      cmpl_ptr <= eng_val;
      cmpl_irq <= 1'b1;
    end else if (sw_we && sw_val == cmpl_ptr) begin
      cmpl_irq <= 1'b0;
    end
  end

  p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpl_irq) |-> $past(eng_set));
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && sw_val == cmpl_ptr && !eng_set) |=> !cmpl_irq);
  p_ptr_only_engine_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_set |=> cmpl_ptr == $past(cmpl_ptr));
endmodule

// File: rtl/dchan_route.sv
module dchan_route (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] mode,
  output logic        dir_en,
  output logic [2:0]  port
);
  import dchan_pkg::*;
  logic [2:0] raw_port;
  logic       legal;

  assign raw_port = mode[PORT_LSB +: 3];
  assign legal    = (raw_port == 3'd1) || (raw_port == 3'd2);
  assign dir_en   = mode[BIT_DIR] && legal;
  assign port     = dir_en ? raw_port : 3'd0;

  p_port_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dir_en |-> (port == 3'd1 || port == 3'd2));
endmodule

// File: rtl/dchan_fsm.sv
module dchan_fsm #(
  parameter int IDX_W   = 6,
  parameter int LEN_W   = 16,
  parameter int CH_W    = 3,
  parameter int CHAN_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_we,
  input  logic [31:0]      head_wdata,
  input  logic             tdown_we,
  input  logic [CH_W-1:0]  tdown_chan,
  input  logic             xfer_ready,
  input  logic             xfer_done,
  input  logic [10:0]      xfer_done_len,
  input  logic [31:0]      eng_rdata,
  output logic [IDX_W-1:0] eng_ridx,
  output logic             eng_we,
  output logic [IDX_W-1:0] eng_widx,
  output logic [31:0]      eng_wdata,
  output logic             cp_set,
  output logic [31:0]      cp_val,
  output logic [31:0]      head_ptr,
  output logic             busy,
  output logic             xfer_valid,
  output logic [31:0]      xfer_addr,
  output logic [LEN_W-1:0] xfer_len,
  output logic [31:0]      desc_mode
);
  import dchan_pkg::*;

  dchan_state_t state_q;
  logic [31:0] head_q, nxt_q, buf_q, len_q, mode_q;
  logic        td_q, seen_q;
  logic [PKTLEN_W-1:0] dlen_q;
  logic        td_hit, tdx, last_c;
  logic [1:0]  word_off;
  logic [IDX_W-3:0] slot;

  assign td_hit = tdown_we && (tdown_chan == CH_W'(CHAN_ID));
  assign tdx    = td_q || td_hit;
  assign last_c = tdx || (nxt_q == 32'd0);
  assign slot   = head_q[IDX_W+1:4];

  always_comb begin
    case (state_q)
      ST_RD_NEXT: word_off = 2'd0;
      ST_RD_BUF:  word_off = 2'd1;
      ST_RD_LEN:  word_off = 2'd2;
      default:    word_off = 2'd3;
    endcase
  end
  assign eng_ridx = {slot, word_off};
  assign eng_widx = {slot, 2'd3};

  // mode word written back at the end of each descriptor
  always_comb begin
    eng_wdata          = mode_q;
    eng_wdata[BIT_OWN] = 1'b0;
    eng_wdata[BIT_EOQ] = last_c;
    eng_wdata[BIT_TDC] = tdx;
    if (seen_q)
      eng_wdata[PKTLEN_W-1:0] = dlen_q +
        (mode_q[BIT_CRC] ? PKTLEN_W'(CRC_BYTES) : '0);
  end

  assign eng_we = (state_q == ST_WB);

  always_comb begin
    cp_set = 1'b0;
    cp_val = head_q;
    if (state_q == ST_WB) begin
      cp_set = 1'b1;
      cp_val = tdx ? TD_MARK : head_q;
    end else if (state_q == ST_IDLE && td_hit) begin
      cp_set = 1'b1;
      cp_val = TD_MARK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      head_q  <= '0;
      nxt_q   <= '0;
      buf_q   <= '0;
      len_q   <= '0;
      mode_q  <= '0;
      td_q    <= 1'b0;
      seen_q  <= 1'b0;
      dlen_q  <= '0;
    end else begin
      if (state_q != ST_IDLE && td_hit) td_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          td_q <= 1'b0;
          if (!td_hit && head_we && head_wdata != 32'd0) begin
            head_q  <= head_wdata;
            state_q <= ST_RD_NEXT;
          end
        end
        ST_RD_NEXT: begin
          nxt_q   <= eng_rdata;
          seen_q  <= 1'b0;
          state_q <= ST_RD_BUF;
        end
        ST_RD_BUF: begin
          buf_q   <= eng_rdata;
          state_q <= ST_RD_LEN;
        end
        ST_RD_LEN: begin
          len_q   <= eng_rdata;
          state_q <= ST_RD_MODE;
        end
        ST_RD_MODE: begin
          mode_q <= eng_rdata;
          if (tdx) begin
            state_q <= ST_WB;
          end else if (!eng_rdata[BIT_OWN]) begin
            head_q  <= '0;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (xfer_ready) begin
            seen_q  <= 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (xfer_done) begin
            dlen_q  <= xfer_done_len;
            state_q <= ST_WB;
          end
        end
        ST_WB: begin
          if (last_c) begin
            head_q  <= '0;
            td_q    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            head_q  <= nxt_q;
            state_q <= ST_RD_NEXT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign xfer_valid = (state_q == ST_REQ);
  assign xfer_addr  = buf_q;
  assign xfer_len   = len_q[LEN_W-1:0];
  assign head_ptr   = head_q;
  assign desc_mode  = mode_q;

  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_len)));
  p_start_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(head_we));
  p_unowned_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_MODE && !td_q && !td_hit && !eng_rdata[BIT_OWN]) |=> (!xfer_valid && !busy));
  p_td_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB && tdx) |=> (!busy && head_ptr == 32'd0));
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma #(
  parameter int MEM_WORDS = 64,
  parameter int LEN_W     = 16,
  parameter int CH_W      = 3,
  parameter int CHAN_ID   = 0,
  localparam int IDX_W    = $clog2(MEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_we,
  input  logic [IDX_W-1:0] mem_idx,
  input  logic [31:0]      mem_wdata,
  output logic [31:0]      mem_rdata,
  input  logic             head_we,
  input  logic [31:0]      head_wdata,
  output logic [31:0]      head_ptr,
  input  logic             cmpl_we,
  input  logic [31:0]      cmpl_wdata,
  output logic [31:0]      cmpl_ptr,
  output logic             cmpl_irq,
  input  logic             tdown_we,
  input  logic [CH_W-1:0]  tdown_chan,
  output logic             busy,
  output logic             xfer_valid,
  input  logic             xfer_ready,
  output logic [31:0]      xfer_addr,
  output logic [LEN_W-1:0] xfer_len,
  output logic             xfer_dir_en,
  output logic [2:0]       xfer_port,
  input  logic             xfer_done,
  input  logic [10:0]      xfer_done_len
);
  logic [IDX_W-1:0] eng_ridx, eng_widx;
  logic [31:0]      eng_rdata, eng_wdata, cp_val, desc_mode;
  logic             eng_we, cp_set;

  dchan_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .sw_we(mem_we), .sw_idx(mem_idx), .sw_wdata(mem_wdata),
    .sw_rdata(mem_rdata), .eng_ridx(eng_ridx), .eng_rdata(eng_rdata),
    .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wdata)
  );

  dchan_fsm #(.IDX_W(IDX_W), .LEN_W(LEN_W), .CH_W(CH_W), .CHAN_ID(CHAN_ID)) u_fsm (
    .clk(clk), .rst_n(rst_n), .head_we(head_we), .head_wdata(head_wdata),
    .tdown_we(tdown_we), .tdown_chan(tdown_chan), .xfer_ready(xfer_ready),
    .xfer_done(xfer_done), .xfer_done_len(xfer_done_len),
    .eng_rdata(eng_rdata), .eng_ridx(eng_ridx), .eng_we(eng_we),
    .eng_widx(eng_widx), .eng_wdata(eng_wdata), .cp_set(cp_set),
    .cp_val(cp_val), .head_ptr(head_ptr), .busy(busy),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .desc_mode(desc_mode)
  );

  dchan_cmpl u_cmpl (
    .clk(clk), .rst_n(rst_n), .eng_set(cp_set), .eng_val(cp_val),
    .sw_we(cmpl_we), .sw_val(cmpl_wdata), .cmpl_ptr(cmpl_ptr), .cmpl_irq(cmpl_irq)
  );

  dchan_route u_route (
    .clk(clk), .rst_n(rst_n), .mode(desc_mode),
    .dir_en(xfer_dir_en), .port(xfer_port)
  );
endmodule

// File: tb/test_desc_chain_dma.sv
module test_desc_chain_dma;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MARK = 32'hFFFF_FFFC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_we = 0; logic [5:0] mem_idx = 0; logic [31:0] mem_wdata = 0;
  logic [31:0] mem_rdata;
  logic head_we = 0; logic [31:0] head_wdata = 0; logic [31:0] head_ptr;
  logic cmpl_we = 0; logic [31:0] cmpl_wdata = 0; logic [31:0] cmpl_ptr;
  logic cmpl_irq, busy, xfer_valid, xfer_dir_en;
  logic tdown_we = 0; logic [2:0] tdown_chan = 0;
  logic xfer_ready = 0, xfer_done = 0; logic [10:0] xfer_done_len = 0;
  logic [31:0] xfer_addr; logic [15:0] xfer_len; logic [2:0] xfer_port;

  int n_vec = 0, n_fail = 0, vcount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_chain_dma i_desc_chain_dma (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_idx(mem_idx),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .head_we(head_we),
    .head_wdata(head_wdata), .head_ptr(head_ptr), .cmpl_we(cmpl_we),
    .cmpl_wdata(cmpl_wdata), .cmpl_ptr(cmpl_ptr), .cmpl_irq(cmpl_irq),
    .tdown_we(tdown_we), .tdown_chan(tdown_chan), .busy(busy),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .xfer_dir_en(xfer_dir_en), .xfer_port(xfer_port),
    .xfer_done(xfer_done), .xfer_done_len(xfer_done_len)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected mode word after writeback
  function automatic logic [31:0] exp_wb(input logic [31:0] m, input bit last, input bit td,
                                         input bit moved, input logic [10:0] dl);
    logic [31:0] r = m;
    r[29] = 1'b0; r[28] = last | td; r[27] = td;
    if (moved) r[10:0] = dl + (m[26] ? 11'd4 : 11'd0);
    return r;
  endfunction

  function automatic bit exp_en(input logic [31:0] m);
    return m[20] && (m[18:16] == 3'd1 || m[18:16] == 3'd2);
  endfunction

  task automatic wr_mem(input int idx, input logic [31:0] v);
    mem_we = 1; mem_idx = 6'(idx); mem_wdata = v;
    @(negedge clk); mem_we = 0;
  endtask

  task automatic rd_mem(input int idx, output logic [31:0] v);
    mem_idx = 6'(idx); #1; v = mem_rdata;
  endtask

  task automatic put_desc(input int slot, input logic [31:0] nx, input logic [31:0] bp,
                          input logic [31:0] ln, input logic [31:0] md);
    wr_mem(slot*4+0, nx); wr_mem(slot*4+1, bp); wr_mem(slot*4+2, ln); wr_mem(slot*4+3, md);
  endtask

  task automatic head(input logic [31:0] a);
    head_we = 1; head_wdata = a; @(negedge clk); head_we = 0;
  endtask

  task automatic ack(input logic [31:0] v);
    cmpl_we = 1; cmpl_wdata = v; @(negedge clk); cmpl_we = 0;
  endtask

  task automatic tdown(input logic [2:0] ch);
    tdown_we = 1; tdown_chan = ch; @(negedge clk); tdown_we = 0;
  endtask

  task automatic wait_valid;
    for (int w = 0; w < 100 && !xfer_valid; w++) @(negedge clk);
  endtask

  task automatic serve(input logic [31:0] md, input logic [31:0] bp, input logic [31:0] ln,
                       input logic [10:0] dl, input int stall, input bit td_mid);
    wait_valid();
    chk(xfer_valid == 1, "R2 request raised", 32'(xfer_valid), 1);
    chk(xfer_addr == bp, "R2 buffer pointer", xfer_addr, bp);
    chk(xfer_len == ln[15:0], "R2 buffer length", 32'(xfer_len), 32'(ln[15:0]));
    chk(xfer_dir_en == exp_en(md), "R11 directed enable", 32'(xfer_dir_en), 32'(exp_en(md)));
    chk(xfer_port == (exp_en(md) ? md[18:16] : 3'd0), "R11 port", 32'(xfer_port),
        32'(exp_en(md) ? md[18:16] : 3'd0));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(xfer_valid && xfer_addr == bp, "R3 held under back-pressure", xfer_addr, bp);
    end
    xfer_ready = 1; @(negedge clk); xfer_ready = 0;
    chk(xfer_valid == 0, "R3 low while waiting for done", 32'(xfer_valid), 0);
    if (td_mid) tdown(3'd0);
    for (int s = 0; s < stall % 3; s++) @(negedge clk);
    xfer_done = 1; xfer_done_len = dl; @(negedge clk); xfer_done = 0;
  endtask

  task automatic wait_idle;
    vcount = 0;
    for (int w = 0; w < 100 && busy; w++) begin
      if (xfer_valid) vcount++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, m1, m2;
    logic [31:0] md [4]; logic [31:0] bp [4]; logic [31:0] ln [4];
    logic [10:0] dl [4]; int sl [4];
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1 reset state
    chk(!busy && !xfer_valid && !cmpl_irq, "R1 reset flags", {busy, xfer_valid, cmpl_irq}, 0);
    chk(head_ptr == 0 && cmpl_ptr == 0, "R1 reset pointers", head_ptr | cmpl_ptr, 0);

    // R8 head write of zero ignored
    head(32'd0); @(negedge clk);
    chk(!busy, "R8 zero head ignored", 32'(busy), 0);

    // R4 unowned descriptor
    m1 = 32'hC000_0040;
    put_desc(7, 32'd0, 32'h1000, 32'd64, m1);
    head(32'd112); wait_idle();
    rd_mem(7*4+3, v);
    chk(v == m1, "R4 unowned mode untouched", v, m1);
    chk(vcount == 0 && !cmpl_irq, "R4 no request or completion", 32'(vcount), 0);
    chk(head_ptr == 0, "R4 head cleared", head_ptr, 0);

    // R10 teardown for another channel ignored
    tdown(3'd5); @(negedge clk);
    chk(!cmpl_irq && cmpl_ptr == 0, "R10 foreign teardown ignored", cmpl_ptr, 0);

    // R10 teardown while idle, R9 acknowledge
    tdown(3'd0);
    chk(cmpl_irq && cmpl_ptr == MARK, "R10 idle teardown marker", cmpl_ptr, MARK);
    ack(32'h0000_0010);
    chk(cmpl_irq == 1, "R9 wrong acknowledge keeps flag", 32'(cmpl_irq), 1);
    ack(MARK);
    chk(cmpl_irq == 0, "R9 matching acknowledge clears", 32'(cmpl_irq), 0);

    // R2 R5 R6 R7 R11 random chains
    for (int t = 0; t < 24; t++) begin
      int k = 1 + int'($urandom % 4);
      int base = int'($urandom % 15);
      for (int i = 0; i < k; i++) begin
        sl[i] = ((base + i*7) % 15) + 1;
        md[i] = 32'hC000_0000 | (32'd1 << 29) | ($urandom & 32'h1411_07FF) | (($urandom % 4) << 16);
        bp[i] = $urandom; ln[i] = $urandom; dl[i] = 11'($urandom);
        if (t == 0 && i == 0) begin md[i][26] = 1'b1; dl[i] = 11'h7FE; end // wrap corner
      end
      for (int i = 0; i < k; i++)
        put_desc(sl[i], (i == k-1) ? 32'd0 : 32'(sl[i+1]*16), bp[i], ln[i], md[i]);
      head(32'(sl[0]*16));
      for (int i = 0; i < k; i++) serve(md[i], bp[i], ln[i], dl[i], int'($urandom % 4), 1'b0);
      wait_idle();
      for (int i = 0; i < k; i++) begin
        rd_mem(sl[i]*4+3, v);
        chk(v == exp_wb(md[i], i == k-1, 1'b0, 1'b1, dl[i]), "R5 R6 R7 mode writeback", v,
            exp_wb(md[i], i == k-1, 1'b0, 1'b1, dl[i]));
      end
      chk(head_ptr == 0 && !busy, "R7 idle after queue end", head_ptr, 0);
      chk(cmpl_irq && cmpl_ptr == 32'(sl[k-1]*16), "R5 completion pointer", cmpl_ptr, 32'(sl[k-1]*16));
      ack(cmpl_ptr);
      chk(!cmpl_irq, "R9 acknowledge after chain", 32'(cmpl_irq), 0);
    end

    // R8 head write while busy is ignored
    m1 = 32'hE001_0020; m2 = 32'hE002_0030;
    put_desc(4, 32'd80, 32'hA0, 32'd20, m1);
    put_desc(5, 32'd0, 32'hB0, 32'd30, m2);
    put_desc(6, 32'd0, 32'hC0, 32'd40, 32'hE000_0040);
    head(32'd64); head(32'd96);
    serve(m1, 32'hA0, 32'd20, 11'd9, 2, 1'b0);
    serve(m2, 32'hB0, 32'd30, 11'd8, 1, 1'b0);
    wait_idle();
    rd_mem(6*4+3, v);
    chk(v == 32'hE000_0040 && vcount == 0, "R8 busy head write ignored", v, 32'hE000_0040);
    chk(cmpl_ptr == 32'd80, "R7 chain followed to second", cmpl_ptr, 32'd80);
    ack(cmpl_ptr);

    // R10 teardown during a transfer
    m1 = 32'hE014_0100; m2 = 32'hE000_0200;
    put_desc(1, 32'd32, 32'h11, 32'd100, m1);
    put_desc(2, 32'd48, 32'h22, 32'd200, m2);
    put_desc(3, 32'd0, 32'h33, 32'd300, m2);
    head(32'd16);
    serve(m1, 32'h11, 32'd100, 11'd77, 1, 1'b1);
    wait_idle();
    rd_mem(1*4+3, v);
    chk(v == exp_wb(m1, 1'b1, 1'b1, 1'b1, 11'd77), "R10 torn descriptor marked", v,
        exp_wb(m1, 1'b1, 1'b1, 1'b1, 11'd77));
    rd_mem(2*4+3, v);
    chk(v == m2 && vcount == 0, "R10 next descriptor untouched", v, m2);
    chk(cmpl_irq && cmpl_ptr == MARK && head_ptr == 0, "R10 marker and idle", cmpl_ptr, MARK);
    ack(MARK);

    // R10 teardown during fetch: no transfer, length kept
    put_desc(9, 32'd0, 32'h99, 32'd50, m2);
    head(32'd144); tdown(3'd0);
    wait_idle();
    rd_mem(9*4+3, v);
    chk(v == exp_wb(m2, 1'b1, 1'b1, 1'b0, 11'd0), "R10 fetch teardown keeps length", v,
        exp_wb(m2, 1'b1, 1'b1, 1'b0, 11'd0));
    chk(vcount == 0 && cmpl_ptr == MARK, "R10 no request on fetch teardown", cmpl_ptr, MARK);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule